// File: doc/BRIEF.md
# Controllable 64-bit Timebase Counter

This block is the shared time reference of a timer subsystem. A 64-bit count advances by one on every clock and is exported without delay to the capture and pulse-generation units next to it. Software controls the count through a small word-wide register port with plain write and read strobes. One control word carries four controls: a level-sensitive reset, a freeze, a one-shot clear and a one-shot load. The load takes a 64-bit value that software stages beforehand in two word registers, and applies both halves on the same edge. Software reads the count as two words. A read of the low word captures the high word at the same moment, so the following high-word read gives a value that matches it.

The count output is a continuous value, not a stream. It has no valid or ready signal and cannot be back-pressured: a consumer samples it whenever it needs to. Read data is registered. It appears on `rdata` after the clock edge that samples `rd_en` and stays there until the next read.

Top module: `timebase_ctr`

## Requirements
- R1: While `rst_n` is low, `count_o`, `rdata` and all control state are zero.
- R2: With no control active, `count_o` increases by exactly one on every clock edge.
- R3: Control bit 2 is a level reset. From the edge after a write that sets it, `count_o` is zero and stays zero while the bit remains set. After a write that clears it, the count stays zero on that write's edge and then counts up from zero.
- R4: Control bit 1 freezes the count from the edge after the write that sets it. After a write that clears it, counting resumes from the frozen value one edge after that write.
- R5: Control bit 3 is a self-clearing clear. On the edge after the write, `count_o` becomes zero and then counts on. The bit always reads back as 0.
- R6: Control bit 0 is a self-clearing load. On the edge after the write, `count_o` becomes {word at address 2, word at address 1}, with address 1 holding the low half. Counting continues from that value, and the bit always reads back as 0.
- R7: A clear and a load in the same control write give a count of zero.
- R8: Freeze does not block a load or a clear. With the count frozen, either one takes effect and the new value then stays frozen.
- R9: While the reset bit is set, a load or a clear leaves `count_o` at zero.
- R10: A read of address 3 returns the low count word and, on the same edge, captures the high word. A later read of address 4 returns that captured word, even if the live high word has changed since.
- R11: The carry crosses the 32-bit word boundary, and the count wraps from all ones to zero.
- R12: Register map (word addresses): 0 control, 1 load low, 2 load high, 3 count low, 4 captured count high. Control reads back freeze in bit 1 and reset in bit 2. The load registers read back as written, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| count_o | output | 64 | Live timebase count |

## Verification
The load path is driven from a table of seed values and wait lengths. The seeds are a small value, a low word of all ones, the all-ones value and a mixed pattern. Each seed shows whether the load is applied whole, and whether the carry moves correctly into the high word and wraps at the top. Directed sequences then combine the controls: freeze with load, freeze with clear, clear with load, and reset with load. These show the priority order and the edge on which each control acts. A low-word read is followed by a wait long enough for the high word to change. This shows whether the high word was captured at the low read or read live.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  // word addresses
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_LD_LO  = 1;
  localparam int unsigned REG_LD_HI  = 2;
  localparam int unsigned REG_CNT_LO = 3;
  localparam int unsigned REG_CNT_HI = 4;
  // control word bit positions
  localparam int unsigned BIT_LOAD = 0;
  localparam int unsigned BIT_HOLD = 1;
  localparam int unsigned BIT_RST  = 2;
  localparam int unsigned BIT_CLR  = 3;
endpackage

// File: rtl/timebase_regs.sv
module timebase_regs
  import timebase_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             hold_q,
  output logic             rst_q,
  output logic             clr_p,
  output logic             ld_p,
  output logic [CNT_W-1:0] ld_val,
  output logic [DW-1:0]    ctrl_word
);
  localparam int NW = CNT_W / DW;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == AW'(REG_CTRL));

  // level controls and one-cycle pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rst_q  <= 1'b0;
      clr_p  <= 1'b0;
      ld_p   <= 1'b0;
    end else begin
      clr_p <= 1'b0;
      ld_p  <= 1'b0;
      if (ctrl_wr) begin
        hold_q <= wdata[BIT_HOLD];
        rst_q  <= wdata[BIT_RST];
        clr_p  <= wdata[BIT_CLR];
        ld_p   <= wdata[BIT_LOAD];
      end
    end
  end

  // staged load words, one register per word of the count
  for (genvar w = 0; w < NW; w++) begin : g_ldw
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (addr == AW'(REG_LD_LO + w)))
        word_q <= wdata;
    end
    assign ld_val[w*DW +: DW] = word_q;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_HOLD] = hold_q;
    ctrl_word[BIT_RST]  = rst_q;
  end
endmodule

// File: rtl/timebase_count.sv
module timebase_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_q,
  input  logic             hold_q,
  input  logic             clr_p,
  input  logic             ld_p,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count
);
  // priority: reset level, clear, load, then increment unless frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (rst_q || clr_p)
      count <= '0;
    else if (ld_p)
      count <= ld_val;
    else if (!hold_q)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/timebase_rdback.sv
module timebase_rdback
  import timebase_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [DW-1:0]    ctrl_word,
  output logic [DW-1:0]    rdata
);
  localparam int HI_W = CNT_W - DW;

  logic [HI_W-1:0] shadow_hi;
  logic [DW-1:0]   sel_data;
  logic            lo_rd;

  assign lo_rd = rd_en && (addr == AW'(REG_CNT_LO));

  always_comb begin
    if (addr == AW'(REG_CTRL))
      sel_data = ctrl_word;
    else if (addr == AW'(REG_LD_LO))
      sel_data = ld_val[DW-1:0];
    else if (addr == AW'(REG_LD_HI))
      sel_data = ld_val[CNT_W-1:DW];
    else if (addr == AW'(REG_CNT_LO))
      sel_data = count[DW-1:0];
    else if (addr == AW'(REG_CNT_HI))
      sel_data = shadow_hi;
    else
      sel_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      shadow_hi <= '0;
    end else begin
      if (rd_en)
        rdata <= sel_data;
      if (lo_rd)
        shadow_hi <= count[CNT_W-1:DW];
    end
  end
endmodule

// File: rtl/timebase_ctr.sv
module timebase_ctr #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] count_o
);
  localparam int CNT_W = 2 * DW;

  logic             hold_q;
  logic             rst_q;
  logic             clr_p;
  logic             ld_p;
  logic [CNT_W-1:0] ld_val;
  logic [DW-1:0]    ctrl_word;

  timebase_regs #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hold_q(hold_q), .rst_q(rst_q), .clr_p(clr_p), .ld_p(ld_p),
    .ld_val(ld_val), .ctrl_word(ctrl_word)
  );

  timebase_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q), .hold_q(hold_q),
    .clr_p(clr_p), .ld_p(ld_p), .ld_val(ld_val), .count(count_o)
  );

  timebase_rdback #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_rdback (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .count(count_o), .ld_val(ld_val), .ctrl_word(ctrl_word), .rdata(rdata)
  );
endmodule

// File: rtl/timebase_ctr_chk.sv
module timebase_ctr_chk #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    rdata,
  input logic [CNT_W-1:0] count_o,
  input logic             rst_q,
  input logic             hold_q,
  input logic             clr_p,
  input logic             ld_p,
  input logic [CNT_W-1:0] ld_val
);
  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_q && !clr_p && !ld_p && !hold_q) |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R3
  rst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (count_o == '0));

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !rst_q && !clr_p && !ld_p) |=> $stable(count_o));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> (count_o == '0));

  // R6
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_p && !clr_p && !rst_q) |=> (count_o == $past(ld_val)));

  // R10
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(3)) |=> (rdata == $past(count_o[DW-1:0])));
endmodule

bind timebase_ctr timebase_ctr_chk #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .count_o(count_o), .rst_q(rst_q), .hold_q(hold_q), .clr_p(clr_p),
  .ld_p(ld_p), .ld_val(ld_val)
);

// File: tb/timebase_ctr_test.sv
module timebase_ctr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [63:0] count_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  timebase_ctr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .count_o(count_o)
  );

  // load vectors: seed, cycles waited after the load lands, expected count
  localparam logic [63:0] VEC_VAL [5] = '{64'h10, 64'h10, 64'hFFFF_FFFF,
                                           64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0};
  localparam int          VEC_WAIT[5] = '{0, 5, 1, 1, 3};
  localparam logic [63:0] VEC_EXP [5] = '{64'h10, 64'h15, 64'h1_0000_0000,
                                           64'h0, 64'h1234_5678_9ABC_DEF3};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load(input logic [63:0] v, input logic [31:0] ctl);
    wr(3'd1, v[31:0]);
    wr(3'd2, v[63:32]);
    wr(3'd0, ctl);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    step(3);
    chk("R1 count in reset", count_o, 64'h0);
    chk("R1 rdata in reset", {32'h0, rdata}, 64'h0);
    rst_n = 1'b1;
    step(1);
    rd(3'd0);
    chk("R1 control after reset", {32'h0, rdata}, 64'h0);

    // R2 free run
    a = count_o;
    step(10);
    chk("R2 free run +10", count_o, a + 64'd10);

    // R6 and R11 via the vector table
    for (int i = 0; i < 5; i++) begin
      load(VEC_VAL[i], 32'h1);
      step(1);
      chk("R6 load lands", count_o, VEC_VAL[i]);
      step(VEC_WAIT[i]);
      chk("R11 count after load", count_o, VEC_EXP[i]);
    end

    // R10 captured high word
    load(64'h0000_0007_FFFF_FFF0, 32'h1);
    step(1);
    rd(3'd3);
    chk("R10 low word", {32'h0, rdata}, 64'hFFFF_FFF0);
    step(20);
    chk("R10 live high moved", {32'h0, count_o[63:32]}, 64'h8);
    rd(3'd4);
    chk("R10 captured high", {32'h0, rdata}, 64'h7);

    // R4 freeze
    wr(3'd0, 32'h2);
    a = count_o;
    step(5);
    chk("R4 frozen", count_o, a);
    rd(3'd0);
    chk("R12 control reads freeze", {32'h0, rdata}, 64'h2);

    // R8 load and clear while frozen
    load(64'hDEAD_BEEF_0000_0100, 32'h3);
    step(1);
    chk("R8 load while frozen", count_o, 64'hDEAD_BEEF_0000_0100);
    step(4);
    chk("R8 stays frozen after load", count_o, 64'hDEAD_BEEF_0000_0100);
    wr(3'd0, 32'hA);
    step(1);
    chk("R8 clear while frozen", count_o, 64'h0);
    step(3);
    chk("R8 stays zero frozen", count_o, 64'h0);
    wr(3'd0, 32'h0);
    chk("R4 release edge frozen", count_o, 64'h0);
    step(3);
    chk("R4 resumes", count_o, 64'h3);

    // R5 clear
    step(7);
    wr(3'd0, 32'h8);
    step(1);
    chk("R5 clear zero", count_o, 64'h0);
    step(2);
    chk("R5 counts after clear", count_o, 64'h2);
    rd(3'd0);
    chk("R5 clear bit reads 0", {32'h0, rdata}, 64'h0);

    // R7 clear beats load
    load(64'h5555_AAAA_1234_0000, 32'h9);
    step(1);
    chk("R7 clear wins", count_o, 64'h0);

    // R9 and R3 reset level
    step(4);
    wr(3'd0, 32'h4);
    step(1);
    chk("R3 reset zero", count_o, 64'h0);
    step(5);
    chk("R3 held zero", count_o, 64'h0);
    load(64'h0000_0001_0000_0001, 32'h5);
    step(2);
    chk("R9 load ignored in reset", count_o, 64'h0);
    wr(3'd0, 32'h0);
    chk("R3 release edge zero", count_o, 64'h0);
    step(1);
    chk("R3 resumes from zero", count_o, 64'h1);

    // R12 map readback
    wr(3'd1, 32'hA5A5_0001);
    rd(3'd1);
    chk("R12 load low readback", {32'h0, rdata}, 64'hA5A5_0001);
    rd(3'd2);
    chk("R12 load high readback", {32'h0, rdata}, 64'h0000_0001);
    rd(3'd7);
    chk("R12 unmapped reads zero", {32'h0, rdata}, 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule